// File: doc/BRIEF.md
# Multi-Core Level Interrupt Router

This block gathers level-sensitive interrupt lines and presents one request output to each of up to four processor cores. Every source carries a class. Low-numbered private sources are gated by a mask that each core holds for itself. Higher-numbered shared sources are gated by a single global enable and by a routing word that names the cores which may receive them. Sources 0 and 1 come from a separate doorbell unit, which supplies one summary bit per core for the inter-processor doorbell and one for the message-signalled doorbell.

Software reaches the block over a simple register bus that has two regions, selected by a region bit. The global region holds a read-only control word, the enable-set and enable-clear registers, and one routing word per source. The per-core region is addressed by a core number on the bus. It holds the mask-set and mask-clear registers and the acknowledge register. Enables and masks are never written as bit vectors. Software writes a single source number to a set or clear register. An acknowledge read changes no state: a source stays pending for as long as its line is high.

Top module: `mcic_top`

## Requirements
- R1: After reset every shared source is disabled, every private source is masked for every core, and every routing word reads 0. With all inputs high, irq_o stays 0 and every acknowledge read returns 1023.
- R2: A read of global offset 0x000 returns the number of implemented sources in bits [11:2]. All other bits read 0, so the value is 0x100 when there are 64 sources.
- R3: Writing a shared source number in wdata[9:0] to global offset 0x030 enables that source. Writing it to global offset 0x034 disables it.
- R4: A per-core write of a private source number to offset 0x048 masks that source for the addressed core only. A write to offset 0x04C unmasks it. Sources 0 through 28 are private.
- R5: A shared source (29 and up) is pending for core c only when its line is high, the source is enabled, and bit c of its routing word is set. Routing words have no effect on private sources.
- R6: The routing word of source n is at global offset 0x100 + 4n. Bits [3:0] hold the delivery bits and bits [11:8] hold the FIQ bits, one bit per core. Only these eight bits are stored and read back. The FIQ bits never cause delivery.
- R7: A read of per-core offset 0x044 returns, in bits [9:0], the lowest-numbered source pending for that core, or 1023 when none is pending. The read has no side effect, so a source remains pending until its line falls.
- R8: For core c, source 0 takes its level from the inter-processor doorbell summary bit c, and source 1 takes its level from the message doorbell summary bit c.
- R9: Read data appears with bus_rvalid_o in the cycle after the request, and writes produce no bus_rvalid_o. irq_o[c] is registered and reflects pending state one cycle after a change.
- R10: Writes are ignored when the source number is at or above the source count. Enable writes that name a private source are ignored, and so are mask writes that name a shared source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_valid_i | input | 1 | Bus request strobe, one cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_percore_i | input | 1 | 1 = per-core region, 0 = global region |
| bus_core_i | input | CORE_W | Core whose per-core region is addressed |
| bus_addr_i | input | ADDR_W | Byte offset within the region |
| bus_wdata_i | input | 32 | Write data |
| bus_rvalid_o | output | 1 | Read data valid |
| bus_rdata_o | output | 32 | Read data |
| periph_src_i | input | NUM_SRC-2 | Levels of sources 2 and up (bit n drives source n) |
| ipi_sum_i | input | NUM_CORES | Inter-processor doorbell summary, one bit per core |
| msg_sum_i | input | NUM_CORES | Message doorbell summary, one bit per core |
| irq_o | output | NUM_CORES | Interrupt request to each core |

## Verification
The assertions check the bus protocol on every cycle: a read returns data in the next cycle, and a write returns none. They also check that every control-word read reports the source count, that an acknowledge result is either a valid source number or 1023, and that the acknowledge result agrees with the same core's irq_o. Only the bench scenarios can show which source wins or which core receives it. These scenarios cover enable, mask, and routing updates, private-shared boundaries at 28 and 29, doorbell steering, and ignored writes.

// File: rtl/mcic_pkg.sv
package mcic_pkg;
    localparam int unsigned ID_W       = 10;
    localparam logic [ID_W-1:0] ID_NONE = 10'd1023;
    localparam int unsigned MAX_CORES  = 4;

    // global region offsets
    localparam int unsigned OFF_CTRL   = 'h000;
    localparam int unsigned OFF_EN_SET = 'h030;
    localparam int unsigned OFF_EN_CLR = 'h034;
    localparam int unsigned OFF_ROUTE  = 'h100;
    // per-core region offsets
    localparam int unsigned OFF_ACK    = 'h044;
    localparam int unsigned OFF_MSK_SET = 'h048;
    localparam int unsigned OFF_MSK_CLR = 'h04C;

    typedef struct packed {
        logic [MAX_CORES-1:0] fiq;
        logic [MAX_CORES-1:0] irq;
    } route_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_EN_SET,
        OP_EN_CLR,
        OP_MSK_SET,
        OP_MSK_CLR,
        OP_ROUTE
    } op_e;
endpackage

// File: rtl/mcic_regs.sv
module mcic_regs
    import mcic_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 64,
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned PRIV_LAST = 28,
    localparam int unsigned SRC_W    = $clog2(NUM_SRC),
    localparam int unsigned CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  op_e                               op_i,
    input  logic [ID_W-1:0]                   idx_i,
    input  logic [CORE_W-1:0]                 core_i,
    input  route_t                            route_i,
    output logic [NUM_SRC-1:0]                en_o,
    output logic [NUM_CORES-1:0][NUM_SRC-1:0] mask_o,
    output route_t [NUM_SRC-1:0]              route_o
);
    typedef struct packed {
        logic [NUM_SRC-1:0]                en;
        logic [NUM_CORES-1:0][NUM_SRC-1:0] mask;
        route_t [NUM_SRC-1:0]              route;
    } state_t;

    state_t st_d, st_q;
    logic   in_range, is_priv;
    logic [SRC_W-1:0] sel;

    always_comb begin
        st_d     = st_q;
        in_range = idx_i < ID_W'(NUM_SRC);
        is_priv  = idx_i <= ID_W'(PRIV_LAST);
        sel      = idx_i[SRC_W-1:0];
        if (in_range) begin
            unique case (op_i)
                OP_EN_SET:  if (!is_priv) st_d.en[sel] = 1'b1;
                OP_EN_CLR:  if (!is_priv) st_d.en[sel] = 1'b0;
                OP_MSK_SET: if (is_priv)  st_d.mask[core_i][sel] = 1'b1;
                OP_MSK_CLR: if (is_priv)  st_d.mask[core_i][sel] = 1'b0;
                OP_ROUTE:   st_d.route[sel] = route_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.en    <= '0;
            st_q.mask  <= '1;
            st_q.route <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o    = st_q.en;
    assign mask_o  = st_q.mask;
    assign route_o = st_q.route;
endmodule

// File: rtl/mcic_gate.sv
module mcic_gate
    import mcic_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 64,
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned PRIV_LAST = 28
) (
    input  logic [NUM_SRC-1:0]                en_i,
    input  logic [NUM_CORES-1:0][NUM_SRC-1:0] mask_i,
    input  route_t [NUM_SRC-1:0]              route_i,
    input  logic [NUM_SRC-1:2]                periph_src_i,
    input  logic [NUM_CORES-1:0]              ipi_sum_i,
    input  logic [NUM_CORES-1:0]              msg_sum_i,
    output logic [NUM_CORES-1:0][NUM_SRC-1:0] pend_o
);
    logic [NUM_CORES-1:0] unused_mask;
    logic                 unused_rest;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
            logic level;
            if (n == 0) begin : g_ipi
                assign level = ipi_sum_i[c];
            end else if (n == 1) begin : g_msg
                assign level = msg_sum_i[c];
            end else begin : g_dev
                assign level = periph_src_i[n];
            end
            if (n <= PRIV_LAST) begin : g_priv
                assign pend_o[c][n] = level & ~mask_i[c][n];
            end else begin : g_shared
                assign pend_o[c][n] = level & en_i[n] & route_i[n].irq[c];
            end
        end
        // mask bits of shared sources carry no meaning
        assign unused_mask[c] = ^mask_i[c][NUM_SRC-1:PRIV_LAST+1];
    end

    always_comb begin
        unused_rest = ^en_i[PRIV_LAST:0];
        for (int n = 0; n < NUM_SRC; n++) begin
            unused_rest = unused_rest ^ (^route_i[n].fiq);
            if (n <= PRIV_LAST) unused_rest = unused_rest ^ (^route_i[n].irq);
        end
        for (int c = NUM_CORES; c < MAX_CORES; c++) begin
            for (int n = 0; n < NUM_SRC; n++) unused_rest = unused_rest ^ route_i[n].irq[c];
        end
    end
endmodule

// File: rtl/mcic_prio.sv
module mcic_prio
    import mcic_pkg::*;
#(
    parameter int unsigned NUM_SRC = 64
) (
    input  logic [NUM_SRC-1:0] pend_i,
    output logic [ID_W-1:0]    id_o
);
    always_comb begin
        id_o = ID_NONE;
        for (int n = NUM_SRC - 1; n >= 0; n--) begin
            if (pend_i[n]) id_o = ID_W'(n);
        end
    end
endmodule

// File: rtl/mcic_top.sv
module mcic_top
    import mcic_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 64,
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned PRIV_LAST = 28,
    parameter int unsigned ADDR_W    = 12,
    localparam int unsigned CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 bus_valid_i,
    input  logic                 bus_write_i,
    input  logic                 bus_percore_i,
    input  logic [CORE_W-1:0]    bus_core_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [31:0]          bus_wdata_i,
    output logic                 bus_rvalid_o,
    output logic [31:0]          bus_rdata_o,
    input  logic [NUM_SRC-1:2]   periph_src_i,
    input  logic [NUM_CORES-1:0] ipi_sum_i,
    input  logic [NUM_CORES-1:0] msg_sum_i,
    output logic [NUM_CORES-1:0] irq_o
);
    localparam int unsigned SRC_W = $clog2(NUM_SRC);
    localparam logic [ADDR_W:0] ROUTE_END = (ADDR_W+1)'(OFF_ROUTE + 4 * NUM_SRC);

    typedef struct packed {
        logic                 rvalid;
        logic [31:0]          rdata;
        logic [NUM_CORES-1:0] irq;
    } out_t;

    out_t out_d, out_q;

    op_e                               op;
    logic [ID_W-1:0]                   idx;
    route_t                            route_w;
    logic                              route_hit;
    logic [ADDR_W-1:0]                 route_off;
    logic [SRC_W-1:0]                  ridx;
    logic [NUM_SRC-1:0]                en;
    logic [NUM_CORES-1:0][NUM_SRC-1:0] mask;
    route_t [NUM_SRC-1:0]              route;
    logic [NUM_CORES-1:0][NUM_SRC-1:0] pend;
    logic [ID_W-1:0]                   ack_id [NUM_CORES];
    logic                              unused_wdata;

    assign unused_wdata = ^{bus_wdata_i[31:12], bus_wdata_i[7:4]};

    // address decode
    always_comb begin
        route_off = bus_addr_i - ADDR_W'(OFF_ROUTE);
        ridx      = route_off[SRC_W+1:2];
        route_hit = ({1'b0, bus_addr_i} >= (ADDR_W+1)'(OFF_ROUTE)) &&
                    ({1'b0, bus_addr_i} < ROUTE_END) && (bus_addr_i[1:0] == 2'b00);
        route_w.irq = bus_wdata_i[3:0];
        route_w.fiq = bus_wdata_i[11:8];
        op  = OP_NONE;
        idx = bus_wdata_i[ID_W-1:0];
        if (bus_valid_i && bus_write_i) begin
            if (bus_percore_i) begin
                if (bus_addr_i == ADDR_W'(OFF_MSK_SET))      op = OP_MSK_SET;
                else if (bus_addr_i == ADDR_W'(OFF_MSK_CLR)) op = OP_MSK_CLR;
            end else begin
                if (bus_addr_i == ADDR_W'(OFF_EN_SET))      op = OP_EN_SET;
                else if (bus_addr_i == ADDR_W'(OFF_EN_CLR)) op = OP_EN_CLR;
                else if (route_hit) begin
                    op  = OP_ROUTE;
                    idx = ID_W'(ridx);
                end
            end
        end
    end

    mcic_regs #(
        .NUM_SRC(NUM_SRC), .NUM_CORES(NUM_CORES), .PRIV_LAST(PRIV_LAST)
    ) u_regs (
        .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op), .idx_i(idx),
        .core_i(bus_core_i), .route_i(route_w),
        .en_o(en), .mask_o(mask), .route_o(route)
    );

    mcic_gate #(
        .NUM_SRC(NUM_SRC), .NUM_CORES(NUM_CORES), .PRIV_LAST(PRIV_LAST)
    ) u_gate (
        .en_i(en), .mask_i(mask), .route_i(route),
        .periph_src_i(periph_src_i), .ipi_sum_i(ipi_sum_i), .msg_sum_i(msg_sum_i),
        .pend_o(pend)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_prio
        mcic_prio #(.NUM_SRC(NUM_SRC)) u_prio (
            .pend_i(pend[c]), .id_o(ack_id[c])
        );
    end

    always_comb begin
        out_d.rvalid = bus_valid_i && !bus_write_i;
        out_d.rdata  = '0;
        if (bus_valid_i && !bus_write_i) begin
            if (bus_percore_i) begin
                if (bus_addr_i == ADDR_W'(OFF_ACK))
                    out_d.rdata = {{(32-ID_W){1'b0}}, ack_id[bus_core_i]};
            end else if (bus_addr_i == ADDR_W'(OFF_CTRL)) begin
                out_d.rdata = 32'(NUM_SRC) << 2;
            end else if (route_hit) begin
                out_d.rdata = {20'b0, route[ridx].fiq, 4'b0, route[ridx].irq};
            end
        end
        for (int c = 0; c < NUM_CORES; c++) out_d.irq[c] = |pend[c];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign bus_rvalid_o = out_q.rvalid;
    assign bus_rdata_o  = out_q.rdata;
    assign irq_o        = out_q.irq;
endmodule

// File: rtl/mcic_checker.sv
module mcic_checker
    import mcic_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 64,
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned ADDR_W    = 12,
    localparam int unsigned CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 bus_valid_i,
    input logic                 bus_write_i,
    input logic                 bus_percore_i,
    input logic [CORE_W-1:0]    bus_core_i,
    input logic [ADDR_W-1:0]    bus_addr_i,
    input logic                 bus_rvalid_o,
    input logic [31:0]          bus_rdata_o,
    input logic [NUM_CORES-1:0] irq_o
);
    logic ack_rd, ctrl_rd;
    assign ack_rd  = bus_valid_i && !bus_write_i && bus_percore_i && bus_addr_i == ADDR_W'(OFF_ACK);
    assign ctrl_rd = bus_valid_i && !bus_write_i && !bus_percore_i && bus_addr_i == ADDR_W'(OFF_CTRL);

    a_r9_read_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_valid_i && !bus_write_i) |=> bus_rvalid_o);

    a_r9_no_stray_rvalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_valid_i && !bus_write_i) |=> !bus_rvalid_o);

    a_r2_ctrl_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctrl_rd |=> bus_rdata_o == (32'(NUM_SRC) << 2));

    a_r7_ack_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_rd |=> (bus_rdata_o[31:ID_W] == '0) &&
                   (bus_rdata_o[ID_W-1:0] < ID_W'(NUM_SRC) || bus_rdata_o[ID_W-1:0] == ID_NONE));

    a_r7_ack_matches_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_rd |=> ((bus_rdata_o[ID_W-1:0] == ID_NONE) == !irq_o[$past(bus_core_i)]));
endmodule

bind mcic_top mcic_checker #(
    .NUM_SRC(NUM_SRC), .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)
) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i),
    .bus_percore_i(bus_percore_i), .bus_core_i(bus_core_i), .bus_addr_i(bus_addr_i),
    .bus_rvalid_o(bus_rvalid_o), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
);

// File: tb/sim_mcic_top.sv
module sim_mcic_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0, write = 1'b0, percore = 1'b0;
    logic [1:0]  core = '0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        rvalid;
    logic [31:0] rdata;
    logic [NSRC-1:2] periph = '0;
    logic [3:0]  ipi = '0, msg = '0;
    logic [3:0]  irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mcic_top u0 (
        .clk_i(clk), .rst_ni(rst_n), .bus_valid_i(valid), .bus_write_i(write),
        .bus_percore_i(percore), .bus_core_i(core), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rvalid_o(rvalid), .bus_rdata_o(rdata),
        .periph_src_i(periph), .ipi_sum_i(ipi), .msg_sum_i(msg), .irq_o(irq)
    );

    // monitor: pops an expectation for every returned read (R9)
    always @(negedge clk) begin
        if (rst_n && rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R9 unexpected rvalid: actual=%h expected=none", rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    failures++;
                    $display("FAIL %s read: actual=%0d expected=%0d", t, rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic pc, input logic [1:0] cr, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        valid = 1'b1; write = 1'b1; percore = pc; core = cr; addr = a; wdata = d;
        @(negedge clk);
        valid = 1'b0; write = 1'b0;
    endtask

    task automatic rd(input logic pc, input logic [1:0] cr, input logic [11:0] a,
                      input logic [31:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        valid = 1'b1; write = 1'b0; percore = pc; core = cr; addr = a;
        @(negedge clk);
        valid = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_irq(input logic [3:0] e, input string t);
        checks++;
        if (irq !== e) begin
            failures++;
            $display("FAIL %s irq: actual=%b expected=%b", t, irq, e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        periph = '1; ipi = '1; msg = '1;
        @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1: everything quiet after reset
        chk_irq(4'b0000, "R1");
        rd(1, 0, 12'h044, 32'd1023, "R1 ack core0");
        rd(1, 3, 12'h044, 32'd1023, "R1 ack core3");
        rd(0, 0, 12'h1A0, 32'h0, "R1 route40");
        rd(0, 0, 12'h000, 32'h100, "R2 ctrl");
        periph = '0; ipi = '0; msg = '0;
        settle();

        // R6: routing word storage
        wr(0, 0, 12'h1A0, 32'h8000F5F6);
        rd(0, 0, 12'h1A0, 32'h506, "R6 readback");
        // R3/R5: shared source 40 routed to cores 1,2
        periph[40] = 1'b1;
        settle();
        chk_irq(4'b0000, "R3 disabled");
        wr(0, 0, 12'h030, 32'd40);
        settle();
        chk_irq(4'b0110, "R5 routed");
        rd(1, 1, 12'h044, 32'd40, "R7 ack core1");
        rd(1, 0, 12'h044, 32'd1023, "R6 fiq no delivery");

        // R7: lowest wins, no side effect, level held
        wr(0, 0, 12'h1C8, 32'h2);
        wr(0, 0, 12'h030, 32'd50);
        periph[50] = 1'b1;
        settle();
        rd(1, 1, 12'h044, 32'd40, "R7 lowest");
        rd(1, 1, 12'h044, 32'd40, "R7 no side effect");
        rd(1, 2, 12'h044, 32'd40, "R5 core2");
        periph[40] = 1'b0;
        settle();
        rd(1, 1, 12'h044, 32'd50, "R7 level");
        chk_irq(4'b0010, "R5 single core");
        wr(0, 0, 12'h034, 32'd50);
        settle();
        chk_irq(4'b0000, "R3 disable");
        rd(1, 1, 12'h044, 32'd1023, "R3 disable ack");

        // R4: private source 5
        periph[5] = 1'b1;
        settle();
        chk_irq(4'b0000, "R4 masked");
        wr(0, 0, 12'h030, 32'd5);
        settle();
        chk_irq(4'b0000, "R10 enable of private");
        wr(1, 2, 12'h04C, 32'd5);
        settle();
        chk_irq(4'b0100, "R4 unmask core2");
        rd(1, 2, 12'h044, 32'd5, "R4 ack");
        rd(1, 0, 12'h044, 32'd1023, "R4 other core");
        wr(1, 2, 12'h048, 32'd5);
        settle();
        chk_irq(4'b0000, "R4 remask");
        periph[5] = 1'b0;

        // R8: doorbell summaries
        wr(1, 3, 12'h04C, 32'd0);
        ipi = 4'b0001;
        settle();
        chk_irq(4'b0000, "R8 other core bit");
        ipi = 4'b1000;
        settle();
        chk_irq(4'b1000, "R8 ipi");
        rd(1, 3, 12'h044, 32'd0, "R8 ipi ack");
        ipi = 4'b0000;
        wr(1, 0, 12'h04C, 32'd1);
        msg = 4'b0001;
        settle();
        chk_irq(4'b0001, "R8 msg");
        rd(1, 0, 12'h044, 32'd1, "R8 msg ack");
        msg = 4'b0000;

        // R10: ignored writes
        ipi = 4'b0010;
        wr(1, 1, 12'h04C, 32'd64);
        settle();
        chk_irq(4'b0000, "R10 out of range");
        ipi = 4'b0000;
        periph[40] = 1'b1;
        wr(1, 1, 12'h048, 32'd40);
        settle();
        chk_irq(4'b0110, "R10 mask of shared");
        periph[40] = 1'b0;

        // boundary 28/29
        periph[28] = 1'b1;
        wr(0, 0, 12'h030, 32'd28);
        settle();
        chk_irq(4'b0000, "R10 enable 28");
        wr(1, 0, 12'h04C, 32'd28);
        settle();
        chk_irq(4'b0001, "R4 boundary 28");
        wr(1, 0, 12'h048, 32'd28);
        periph[28] = 1'b0;
        periph[29] = 1'b1;
        wr(1, 0, 12'h04C, 32'd29);
        settle();
        chk_irq(4'b0000, "R10 unmask 29");
        wr(0, 0, 12'h174, 32'h1);
        wr(0, 0, 12'h030, 32'd29);
        settle();
        chk_irq(4'b0001, "R5 shared 29");
        rd(1, 0, 12'h044, 32'd29, "R7 ack 29");

        // R9: irq follows one cycle later
        @(negedge clk);
        periph[29] = 1'b0;
        chk_irq(4'b0001, "R9 registered");
        @(negedge clk);
        chk_irq(4'b0000, "R9 one cycle");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R9 missing reads: actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule